// File: doc/BRIEF.md
# SM3 Compression Round Step Unit

This block performs a single step of the SM3 hash compression round on a four-lane, 32-bit-per-lane state vector. Every accepted request combines the current state `d`, an operand `n` and an operand `m`, and returns the next state one clock later. A two-bit round opcode picks one of four step variants. The variants differ in the boolean function they apply, in how they finish the intermediate sum, and in the rotation they put on the recycled state word. A two-bit word index picks which lane of `m` enters the sum.

A mode input changes the unit to a second function, the SS1 term. That function uses lane 3 of `n`, `m` and a fourth operand `a`, and it returns a vector in which only lane 3 is non-zero. Message expansion, round constants, round counting and instruction decode are not part of the unit. The surrounding pipeline supplies those, with the constant already folded into the operands.

Lane k of every vector occupies bits [32k+31:32k].

Top module: `sm3_step_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next `out_valid` and `q_out` are both zero, whatever the other inputs are.
- R2: `out_valid` equals the `in_valid` of the previous cycle. When `in_valid` is low, `q_out` keeps its value from the previous cycle.
- R3: The round opcode is encoded as 0 (first group, parity), 1 (first group, majority), 2 (second group, parity) and 3 (second group, choose). The function is applied bitwise to the old lanes x=d3, y=d2, z=d1. Parity is x^y^z. Majority is set where at least two inputs are set. Choose takes y where x is set and z otherwise.
- R4: The intermediate sum is f + d0 + m[idx], where `widx` = k selects lane k of `m`.
- R5: For opcodes 0 and 1, the sum gains n3 XOR rotr(d3,20), and the new lane 1 is rotr(d2,23).
- R6: For opcodes 2 and 3, the sum gains n3 and then s is replaced by s XOR rotl(s,9) XOR rotl(s,17). The new lane 1 is rotr(d2,13).
- R7: In round mode, new lane 0 is the old d1, new lane 2 is the old d3, and new lane 3 is the finished sum.
- R8: With `mode_ss1` high, lane 3 of the result is rotr(rotr(n3,20) + m3 + a3, 25).
- R9: With `mode_ss1` high, lanes 0 to 2 of the result are zero, and `d_in`, `opcode` and `widx` have no effect on the result.
- R10: All additions wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe; the operands are taken at this edge |
| mode_ss1 | input | 1 | 1 selects the SS1 term, 0 selects a round step |
| opcode | input | 2 | Round variant, 0 to 3 |
| widx | input | 2 | Lane of `m_in` added into the round sum |
| d_in | input | 128 | Current state lanes |
| n_in | input | 128 | Operand n |
| m_in | input | 128 | Operand m |
| a_in | input | 128 | Operand a, used only by SS1 |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| q_out | output | 128 | Registered result |

## Verification
The round datapath and the SS1 datapath both see the same operands in every cycle, and `mode_ss1` decides which one reaches the register. The bench switches `mode_ss1` on consecutive cycles while it keeps `d_in`, `opcode` and `widx` at values that would give a non-zero round result. Any leak from the round path into the SS1 result therefore shows up in lanes 0 to 2, or as a wrong lane 3. Each cycle is compared against a behavioural model of both functions, so a swap in either direction is reported in the cycle it happens.

// File: rtl/sm3s_pkg.sv
package sm3s_pkg;

   typedef enum logic [1:0] {
      OP_G1_PAR = 2'd0,
      OP_G1_MAJ = 2'd1,
      OP_G2_PAR = 2'd2,
      OP_G2_CHO = 2'd3
   } sm3s_op_e;

   typedef enum logic [1:0] {
      BF_PAR = 2'd0,
      BF_MAJ = 2'd1,
      BF_CHO = 2'd2
   } sm3s_bf_e;

endpackage

// File: rtl/sm3s_boolfn.sv
module sm3s_boolfn #(
   parameter int W = 32
) (
   input  sm3s_pkg::sm3s_bf_e sel,
   input  logic [W-1:0]       x,
   input  logic [W-1:0]       y,
   input  logic [W-1:0]       z,
   output logic [W-1:0]       f
);
   import sm3s_pkg::*;

   always_comb begin
      unique case (sel)
         BF_MAJ:  f = (x & y) | (x & z) | (y & z);
         BF_CHO:  f = (x & y) | (~x & z);
         default: f = x ^ y ^ z;
      endcase
   end
endmodule

// File: rtl/sm3s_round.sv
module sm3s_round #(
   parameter int W         = 32,
   parameter int LANES     = 4,
   parameter int IDX_W     = 2,
   parameter int R_G1_D3   = 20,
   parameter int R_G1_D2   = 23,
   parameter int R_G2_D2   = 13,
   parameter int R_MIX_A   = 9,
   parameter int R_MIX_B   = 17
) (
   input  sm3s_pkg::sm3s_op_e           op,
   input  logic [IDX_W-1:0]             widx,
   input  logic [LANES-1:0][W-1:0]      d,
   input  logic [LANES-1:0][W-1:0]      n,
   input  logic [LANES-1:0][W-1:0]      m,
   output logic [LANES-1:0][W-1:0]      q
);
   import sm3s_pkg::*;

   localparam int TOP = LANES - 1;

   function automatic logic [W-1:0] rotr(input logic [W-1:0] v, input int unsigned r);
      return (v >> r) | (v << (W - r));
   endfunction

   sm3s_bf_e     bf_sel;
   logic [W-1:0] f_val;
   logic [W-1:0] base_sum;
   logic [W-1:0] g1_sum;
   logic [W-1:0] g2_pre;
   logic [W-1:0] g2_sum;
   logic         second_grp;

   // variant group is carried by the opcode high bit
   assign second_grp = op[1];

   always_comb begin
      unique case (op)
         OP_G1_MAJ: bf_sel = BF_MAJ;
         OP_G2_CHO: bf_sel = BF_CHO;
         default:   bf_sel = BF_PAR;
      endcase
   end

   sm3s_boolfn #(.W(W)) u_bf (
      .sel (bf_sel),
      .x   (d[TOP]),
      .y   (d[TOP-1]),
      .z   (d[TOP-2]),
      .f   (f_val)
   );

   assign base_sum = f_val + d[0] + m[widx];
   assign g1_sum   = base_sum + (n[TOP] ^ rotr(d[TOP], R_G1_D3));
   assign g2_pre   = base_sum + n[TOP];
   assign g2_sum   = g2_pre ^ rotr(g2_pre, W - R_MIX_A) ^ rotr(g2_pre, W - R_MIX_B);

   always_comb begin
      q[0]     = d[1];
      q[1]     = second_grp ? rotr(d[2], R_G2_D2) : rotr(d[2], R_G1_D2);
      q[2]     = d[TOP];
      q[TOP]   = second_grp ? g2_sum : g1_sum;
   end
endmodule

// File: rtl/sm3s_ss1.sv
module sm3s_ss1 #(
   parameter int W      = 32,
   parameter int LANES  = 4,
   parameter int R_IN   = 20,
   parameter int R_OUT  = 25
) (
   input  logic [LANES-1:0][W-1:0] n,
   input  logic [LANES-1:0][W-1:0] m,
   input  logic [LANES-1:0][W-1:0] a,
   output logic [LANES-1:0][W-1:0] q
);
   localparam int TOP = LANES - 1;

   function automatic logic [W-1:0] rotr(input logic [W-1:0] v, input int unsigned r);
      return (v >> r) | (v << (W - r));
   endfunction

   logic [W-1:0] acc;

   assign acc    = rotr(n[TOP], R_IN) + m[TOP] + a[TOP];
   assign q[TOP] = rotr(acc, R_OUT);

   for (genvar k = 0; k < TOP; k++) begin : g_zero_lane
      assign q[k] = '0;
   end
endmodule

// File: rtl/sm3_step_unit.sv
module sm3_step_unit #(
   parameter int W     = 32,
   parameter int LANES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 mode_ss1,
   input  logic [1:0]           opcode,
   input  logic [$clog2(LANES)-1:0] widx,
   input  logic [LANES*W-1:0]   d_in,
   input  logic [LANES*W-1:0]   n_in,
   input  logic [LANES*W-1:0]   m_in,
   input  logic [LANES*W-1:0]   a_in,
   output logic                 out_valid,
   output logic [LANES*W-1:0]   q_out
);
   import sm3s_pkg::*;

   localparam int IDX_W = $clog2(LANES);
   localparam int VEC_W = LANES * W;

   if (W != 32) begin : g_bad_width
      $error("sm3_step_unit: lane width must be 32");
   end
   if (LANES != 4) begin : g_bad_lanes
      $error("sm3_step_unit: lane count must be 4");
   end

   logic [LANES-1:0][W-1:0] d_v, n_v, m_v, a_v;
   logic [LANES-1:0][W-1:0] rnd_q, ss1_q, nxt_q;
   sm3s_op_e                op_e;

   assign d_v  = d_in;
   assign n_v  = n_in;
   assign m_v  = m_in;
   assign a_v  = a_in;
   assign op_e = sm3s_op_e'(opcode);

   sm3s_round #(.W(W), .LANES(LANES), .IDX_W(IDX_W)) u_round (
      .op   (op_e),
      .widx (widx),
      .d    (d_v),
      .n    (n_v),
      .m    (m_v),
      .q    (rnd_q)
   );

   sm3s_ss1 #(.W(W), .LANES(LANES)) u_ss1 (
      .n (n_v),
      .m (m_v),
      .a (a_v),
      .q (ss1_q)
   );

   assign nxt_q = mode_ss1 ? ss1_q : rnd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         q_out     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) q_out <= VEC_W'(nxt_q);
      end
   end

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R2
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(q_out)));
   // R9
   ss1_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_ss1) |=> (q_out[3*W-1:0] == '0));
   // R7
   lane_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mode_ss1) |=>
         (q_out[W-1:0] == $past(d_in[2*W-1:W]) &&
          q_out[3*W-1:2*W] == $past(d_in[4*W-1:3*W])));
endmodule

// File: tb/sm3_step_unit_tb.sv
`timescale 1ns/1ps
module sm3_step_unit_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         mode_ss1 = 1'b0;
   logic [1:0]   opcode = '0;
   logic [1:0]   widx = '0;
   logic [127:0] d_in = '0, n_in = '0, m_in = '0, a_in = '0;
   logic         out_valid;
   logic [127:0] q_out;

   int     checks = 0;
   int     errors = 0;
   bit     ev = 1'b0;
   bit [127:0] eq = '0;
   string  prev_tag = "R1";
   bit     done = 1'b0;

   always #4 clk = ~clk;

   sm3_step_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_ss1(mode_ss1),
      .opcode(opcode), .widx(widx), .d_in(d_in), .n_in(n_in), .m_in(m_in),
      .a_in(a_in), .out_valid(out_valid), .q_out(q_out)
   );

   function automatic bit [31:0] rr(bit [31:0] x, int k);
      return (x >> k) | (x << (32 - k));
   endfunction

   function automatic bit [31:0] lane(bit [127:0] v, int k);
      return v[32*k +: 32];
   endfunction

   function automatic bit [127:0] model(bit ss, bit [1:0] op, bit [1:0] ix,
                                        bit [127:0] d, bit [127:0] n,
                                        bit [127:0] m, bit [127:0] a);
      bit [31:0] w[4];
      bit [31:0] x, y, z, f, s;
      bit [127:0] r;
      if (ss) begin
         s = rr(lane(n,3), 20) + lane(m,3) + lane(a,3);
         r = '0;
         r[127:96] = rr(s, 25);
         return r;
      end
      x = lane(d,3); y = lane(d,2); z = lane(d,1);
      for (int b = 0; b < 32; b++) begin
         case (op)
            2'd1:    f[b] = ((int'(x[b]) + int'(y[b]) + int'(z[b])) >= 2);
            2'd3:    f[b] = x[b] ? y[b] : z[b];
            default: f[b] = ((int'(x[b]) + int'(y[b]) + int'(z[b])) % 2) == 1;
         endcase
      end
      s = f + lane(d,0) + lane(m, int'(ix));
      if (op < 2) begin
         s = s + (lane(n,3) ^ rr(lane(d,3), 20));
         w[1] = rr(lane(d,2), 23);
      end else begin
         s = s + lane(n,3);
         s = s ^ rr(s, 23) ^ rr(s, 15);
         w[1] = rr(lane(d,2), 13);
      end
      w[0] = lane(d,1);
      w[2] = lane(d,3);
      w[3] = s;
      return {w[3], w[2], w[1], w[0]};
   endfunction

   task automatic compare(string tag);
      checks++;
      if (out_valid !== ev || q_out !== eq) begin
         errors++;
         $display("FAIL %s: out_valid=%0b q_out=%h expected out_valid=%0b q_out=%h",
                  tag, out_valid, q_out, ev, eq);
      end
   endtask

   task automatic drive(string tag, bit v, bit ss, bit [1:0] op, bit [1:0] ix,
                        bit [127:0] d, bit [127:0] n, bit [127:0] m, bit [127:0] a);
      @(negedge clk);
      compare(prev_tag);
      in_valid = v; mode_ss1 = ss; opcode = op; widx = ix;
      d_in = d; n_in = n; m_in = m; a_in = a;
      prev_tag = tag;
      @(posedge clk);
      #1;
      ev = v;
      if (v) eq = model(ss, op, ix, d, n, m, a);
   endtask

   initial begin
      bit [127:0] dd, nn, mm, aa;
      dd = 128'h0f0f0f0f_33333333_55555555_01234567;
      nn = 128'h89abcdef_11111111_22222222_44444444;
      mm = 128'h00000010_00000200_00003000_00040000;
      aa = 128'hdeadbeef_cafef00d_12345678_9abcdef0;

      // R1: reset wins over an active request
      in_valid = 1'b1; d_in = dd; n_in = nn; m_in = mm;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1; in_valid = 1'b0;
      @(posedge clk); #1;
      ev = 1'b0;

      // R3 R5 R7 first group, each function
      drive("R3", 1, 0, 2'd0, 2'd0, dd, nn, mm, aa);
      drive("R3", 1, 0, 2'd1, 2'd0, dd, nn, mm, aa);
      drive("R5", 1, 0, 2'd1, 2'd2, dd, nn, mm, aa);
      // R3 R6 second group
      drive("R3", 1, 0, 2'd3, 2'd0, dd, nn, mm, aa);
      drive("R6", 1, 0, 2'd2, 2'd1, dd, nn, mm, aa);
      // R4 every word index
      for (int k = 0; k < 4; k++)
         drive("R4", 1, 0, 2'd0, 2'(k), dd, nn, mm, aa);
      // R2 idle cycles with moving inputs: output must hold
      drive("R2", 0, 0, 2'd2, 2'd3, ~dd, ~nn, ~mm, aa);
      drive("R2", 0, 1, 2'd1, 2'd1, nn, dd, aa, mm);
      // R10 wrap-around with all-ones operands
      for (int k = 0; k < 4; k++)
         drive("R10", 1, 0, 2'(k), 2'(k), '1, '1, '1, '1);
      drive("R10", 1, 1, 2'd0, 2'd0, '1, '1, '1, '1);
      // R8 R9 SS1 with round inputs that would be non-zero
      drive("R8", 1, 1, 2'd3, 2'd2, dd, nn, mm, aa);
      drive("R9", 1, 1, 2'd1, 2'd3, ~dd, nn, mm, aa);
      // R9 mode switching back to back on the same operands
      for (int k = 0; k < 6; k++)
         drive("R9", 1, k[0], 2'(k), 2'(k + 1), dd, nn, mm, aa);
      // R7 mixed random traffic
      for (int k = 0; k < 400; k++) begin
         drive("R7", ($urandom % 4) != 0, ($urandom % 3) == 0,
               2'($urandom), 2'($urandom),
               {$urandom, $urandom, $urandom, $urandom},
               {$urandom, $urandom, $urandom, $urandom},
               {$urandom, $urandom, $urandom, $urandom},
               {$urandom, $urandom, $urandom, $urandom});
      end
      drive("R2", 0, 0, 2'd0, 2'd0, '0, '0, '0, '0);
      @(negedge clk);
      compare(prev_tag);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule